// File: doc/BRIEF.md
# Dicode Hysteresis Decision Slicer

This block turns a sampled dicode channel back into binary NRZ data. The channel only responds to transitions of the transmitted bit, so each received sample is close to the difference between the current transmitted bit and the one before it. The sample therefore sits at one of three levels: a positive pulse, a negative pulse, or near zero. One signed sample arrives per unit interval. The block compares it against a decision level whose magnitude comes from a runtime input and whose sign is set by the last decided bit.

When the decided bit is 0, the level is positive and only a clear positive pulse can raise the output. When the decided bit is 1, the level is negative and only a clear negative pulse can lower it. Samples near zero leave the output where it is. The slicer therefore acts as a one-tap decision-feedback equalizer, or a hysteresis latch. The updated level applies to the very next sample.

A synchronous load input presets the decision state before data starts. This lines the output up with the first transmitted bit. A valid strobe qualifies each sample and is passed on with each decided bit.

Top module: `dicode_slicer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bit_out` and `bit_valid` are both 0.
- R2: When the state is 0 and a valid sample is strictly greater than +`thr_mag` (signed compare), `bit_out` is 1 on the cycle after that sample. A sample at or below +`thr_mag` leaves `bit_out` at 0.
- R3: When the state is 1 and a valid sample is strictly less than -`thr_mag`, `bit_out` is 0 on the cycle after that sample. A sample at or above -`thr_mag` leaves `bit_out` at 1.
- R4: A sample exactly equal to the active level does not change the state. That level is +`thr_mag` in state 0 and -`thr_mag` in state 1.
- R5: The decision uses the `thr_mag` value present in the cycle of the sample. A new magnitude takes effect on the very next sample.
- R6: When `init_load` is high, `bit_out` takes the value of `init_bit` on the next cycle and `bit_valid` is 0 on that cycle. The load wins over a valid sample presented in the same cycle, and that sample is discarded.
- R7: `bit_valid` is 1 exactly on the cycle after each valid sample that is not overridden by a load, and 0 otherwise. While `smp_valid` is low, `bit_out` holds its value whatever the sample value.
- R8: For a noiseless or mildly noisy dicode stream, every pulse magnitude exceeds `thr_mag` and every idle sample magnitude stays at or below it. Given this, and with the state loaded with the bit sent before the first sample, `bit_out` reproduces the transmitted NRZ sequence.
- R9: With `thr_mag` = 0, any positive sample sets the state, any negative sample clears it, and a zero sample holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, one sample per cycle at most |
| rst | input | 1 | Synchronous active-high reset |
| thr_mag | input | 7 | Unsigned magnitude of the decision level |
| init_load | input | 1 | Preset the decision state from `init_bit` |
| init_bit | input | 1 | Value loaded into the state |
| smp_valid | input | 1 | Qualifies `smp` in this cycle |
| smp | input | 8 | Received sample, two's complement |
| bit_out | output | 1 | Decided bit, which is also the slicer state |
| bit_valid | output | 1 | High for one cycle per decided sample |

## Verification
The hardest cases to reach are samples that land exactly on the active level, and a change of magnitude that is followed by a sample at once. Random sampling almost never produces either one. Directed steps first steer the state to 0 or 1. They then present samples equal to +T, -T and the values one step past them, and alter `thr_mag` right before a sample that sits between the old and new levels. The dicode stream is built from a random bit sequence with bounded noise. This checks the decoding of full runs and isolated transitions against the transmitted bits, while random mixes of valid, load and sample values cover the gating.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic {
    DEC_LOW  = 1'b0,
    DEC_HIGH = 1'b1
  } dec_state_e;

  function automatic int unsigned cmp_width(input int unsigned sw, input int unsigned tw);
    return ((sw > tw + 1) ? sw : tw + 1) + 1;
  endfunction
endpackage

// File: rtl/dfs_level.sv
module dfs_level #(
  parameter int unsigned THR_W = 7
) (
  input  logic                    cur_state,
  input  logic [THR_W-1:0]        thr_mag,
  output logic signed [THR_W:0]   level
);
  logic signed [THR_W:0] pos_level;

  always_comb begin
    pos_level = $signed({1'b0, thr_mag});
    level     = cur_state ? -pos_level : pos_level;
  end
endmodule

// File: rtl/dfs_compare.sv
module dfs_compare #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned THR_W    = 7
) (
  input  logic                       cur_state,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic signed [THR_W:0]      level,
  output logic                       decision
);
  localparam int unsigned CW = dfs_pkg::cmp_width(SAMPLE_W, THR_W);

  logic signed [CW-1:0] smp_x;
  logic signed [CW-1:0] lvl_x;

  always_comb begin
    smp_x = {{(CW-SAMPLE_W){smp[SAMPLE_W-1]}}, smp};
    lvl_x = {{(CW-THR_W-1){level[THR_W]}}, level};
    if (cur_state) decision = !(smp_x < lvl_x);
    else           decision = (smp_x > lvl_x);
  end
endmodule

// File: rtl/dfs_state.sv
module dfs_state (
  input  logic clk,
  input  logic rst,
  input  logic init_load,
  input  logic init_bit,
  input  logic smp_valid,
  input  logic decision,
  output logic cur_state,
  output logic dec_valid
);
  import dfs_pkg::*;

  dec_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= DEC_LOW;
      dec_valid <= 1'b0;
    end else if (init_load) begin
      st_q      <= dec_state_e'(init_bit);
      dec_valid <= 1'b0;
    end else if (smp_valid) begin
      st_q      <= dec_state_e'(decision);
      dec_valid <= 1'b1;
    end else begin
      dec_valid <= 1'b0;
    end
  end

  assign cur_state = (st_q == DEC_HIGH);

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    init_load |=> (cur_state == $past(init_bit)) && !dec_valid);

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !init_load) |=> dec_valid);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !init_load) |=> $stable(cur_state) && !dec_valid);
endmodule

// File: rtl/dicode_slicer.sv
module dicode_slicer #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned THR_W    = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [THR_W-1:0]           thr_mag,
  input  logic                       init_load,
  input  logic                       init_bit,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic                       bit_out,
  output logic                       bit_valid
);
  logic                  cur_state;
  logic signed [THR_W:0] level;
  logic                  decision;

  dfs_level #(.THR_W(THR_W)) u_level (
    .cur_state (cur_state),
    .thr_mag   (thr_mag),
    .level     (level)
  );

  dfs_compare #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) u_cmp (
    .cur_state (cur_state),
    .smp       (smp),
    .level     (level),
    .decision  (decision)
  );

  dfs_state u_state (
    .clk       (clk),
    .rst       (rst),
    .init_load (init_load),
    .init_bit  (init_bit),
    .smp_valid (smp_valid),
    .decision  (decision),
    .cur_state (cur_state),
    .dec_valid (bit_valid)
  );

  assign bit_out = cur_state;

  assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !init_load && !bit_out && ($signed(smp) > $signed({1'b0, thr_mag})))
    |=> bit_out);

  assert_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !init_load && bit_out && ($signed(smp) < -$signed({1'b0, thr_mag})))
    |=> !bit_out);

  assert_no_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !init_load && !bit_out && ($signed(smp) <= $signed({1'b0, thr_mag})))
    |=> !bit_out);
endmodule

// File: tb/dicode_slicer_test.sv
module dicode_slicer_test;
  localparam int PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [6:0]        thr_mag = 7'd0;
  logic              init_load = 1'b0;
  logic              init_bit = 1'b0;
  logic              smp_valid = 1'b0;
  logic signed [7:0] smp = 8'sd0;
  logic              bit_out;
  logic              bit_valid;

  int total = 0;
  int bad = 0;
  bit model_st = 1'b0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dicode_slicer uut (
    .clk(clk), .rst(rst), .thr_mag(thr_mag), .init_load(init_load),
    .init_bit(init_bit), .smp_valid(smp_valid), .smp(smp),
    .bit_out(bit_out), .bit_valid(bit_valid)
  );

  function automatic bit ref_decide(bit st, int s, int t);
    if (st) return !(s < -t);
    return s > t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, let posedge capture, observe at next negedge
  task automatic step(input bit v, input int s, input bit ld, input bit ib, input string req);
    bit exp_v;
    smp_valid = v; smp = 8'(s); init_load = ld; init_bit = ib;
    exp_v = 1'b0;
    if (ld) model_st = ib;
    else if (v) begin model_st = ref_decide(model_st, s, int'(thr_mag)); exp_v = 1'b1; end
    @(negedge clk);
    chk(bit_out == model_st, req, bit_out, model_st);
    chk(bit_valid == exp_v, req, bit_valid, exp_v);
    smp_valid = 1'b0; init_load = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    bit z_prev;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(bit_out == 1'b0, "R1", bit_out, 0);
    chk(bit_valid == 1'b0, "R1", bit_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bit_out == 1'b0 && bit_valid == 1'b0, "R1", bit_out, 0);
    model_st = 1'b0;

    // R2 / R4 rising side
    thr_mag = 7'd40;
    step(1, 40, 0, 0, "R4");
    step(1, 39, 0, 0, "R2");
    step(1, 41, 0, 0, "R2");
    // R3 / R4 falling side
    step(1, -40, 0, 0, "R4");
    step(1, 0, 0, 0, "R3");
    step(1, -41, 0, 0, "R3");
    step(1, 127, 0, 0, "R2");
    step(1, -128, 0, 0, "R3");
    // R5 threshold change applies at once
    thr_mag = 7'd60;
    step(1, 50, 0, 0, "R5");
    thr_mag = 7'd45;
    step(1, 50, 0, 0, "R5");
    thr_mag = 7'd60;
    step(1, -50, 0, 0, "R5");
    // R6 load and its priority
    step(0, 0, 1, 0, "R6");
    step(1, 100, 1, 0, "R6");
    step(1, -100, 1, 1, "R6");
    // R7 hold while not valid
    step(0, -128, 0, 0, "R7");
    step(0, -128, 0, 0, "R7");
    // R9 zero magnitude
    thr_mag = 7'd0;
    step(1, 0, 0, 0, "R9");
    step(1, -1, 0, 0, "R9");
    step(1, 0, 0, 0, "R9");
    step(1, 1, 0, 0, "R9");

    // R7 random mix of valid, load, sample and magnitude
    for (int i = 0; i < 3000; i++) begin
      thr_mag = 7'($urandom_range(0, 127));
      step(($urandom_range(0, 3) != 0), int'($signed(8'($urandom))),
           ($urandom_range(0, 15) == 0), 1'($urandom), "R7");
    end

    // R8 dicode stream recovery
    thr_mag = 7'd30;
    z_prev = 1'($urandom);
    step(0, 0, 1, z_prev, "R8");
    for (int i = 0; i < 4000; i++) begin
      bit z;
      int s;
      z = ($urandom_range(0, 2) == 0) ? ~z_prev : z_prev;
      s = (int'(z) - int'(z_prev)) * 70 + $urandom_range(0, 40) - 20;
      step(1, s, 0, 0, "R8");
      chk(bit_out == z, "R8", bit_out, z);
      z_prev = z;
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule